// File: doc/BRIEF.md
# One-Shot Writeback Destination Override

This block sits in the writeback path of a processor. An earlier "arm" instruction hands it a destination operand. The block keeps the low address bits of that operand and an enable bit. The next instruction that really writes a register has its result steered to the stored address instead of its own destination field. The override is then spent.

An instruction whose condition fails, or one that writes no register, does not use up the override. The override stays pending until a real register write arrives. Source operands are fetched from the instruction's own fields as usual; only the writeback address changes.

The pending state is ten bits: one enable bit and nine address bits. It is visible on a port, so a task switch can save it, and a restore port loads it back. The final address, redirected or not, passes through a register-remap stage. In this block that stage is modelled as an XOR with a remap key. The arm instruction writes no flags, so the block has no flag outputs.

Top module: `wb_dest_override`

## Requirements
- R1: After reset, `ovrState` is 0. While the enable is clear, `wbAddr` equals `exDestAddr ^ remapKey` in the same cycle.
- R2: When `armValid` is high, the cycle after holds `ovrState` = {1'b1, `armOperand[8:0]`}. The upper operand bits are dropped. The enable is bit 9 and the address is bits 8:0.
- R3: A consuming write is a cycle with `exWritesReg` and `exCondPass` both high while the enable is set. In that cycle `wbAddr` is the stored address after remapping. Without a simultaneous arm or restore, the enable is clear in the next cycle, so the following write uses its own destination again.
- R4: A cycle in which `exCondPass` is low or `exWritesReg` is low, with no arm and no restore, leaves `ovrState` unchanged. In that cycle `wbAddr` is the instruction's own remapped destination.
- R5: A second arm before consumption replaces the pending address, and the enable stays set.
- R6: When an arm and a consuming write fall in the same cycle, the write uses the old pending address. The new arm is pending in the next cycle.
- R7: `ctxRestore` loads `ctxRestoreState` into `ovrState` for the next cycle and wins over a simultaneous arm or consuming write. A write in the restore cycle still sees the old state.
- R8: The remap key is applied to redirected addresses exactly as it is to normal destinations.
- R9: `wbValid` is high exactly when `exWritesReg` and `exCondPass` are both high, whatever the override state or arm input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armValid | input | 1 | Arm instruction executes this cycle |
| armOperand | input | 32 | Destination operand of the arm instruction |
| exWritesReg | input | 1 | Executing instruction produces a register result |
| exCondPass | input | 1 | Executing instruction's condition passed |
| exDestAddr | input | 9 | Instruction's own destination address |
| remapKey | input | 9 | Remap key applied to the final address |
| ctxRestore | input | 1 | Load override state from the saved context |
| ctxRestoreState | input | 10 | Saved state {enable, address} |
| wbValid | output | 1 | Register write happens this cycle |
| wbAddr | output | 9 | Effective, remapped writeback address |
| ovrState | output | 10 | Current state {enable, address} for context save |

## Verification
A stuck or wrongly cleared enable bit shows on `wbAddr` in the first qualifying write after the fault. A result lands at its own destination when it should have been redirected, or the reverse. It also shows on `ovrState` in the next cycle. If the enable is consumed by a condition-failed or non-writing instruction, the fault is silent until the next real write. For that reason the tests always put such instructions before a write and then check the address. A wrong priority among arm, consume and restore appears one cycle after the collision, as a mismatched `ovrState`.

// File: rtl/wb_dest_override_pkg.sv
package wb_dest_override_pkg;

  // Strobes from control to datapath, decoded once per cycle
  typedef struct packed {
    logic loadArm;   // capture a new pending address
    logic consume;   // a real write takes the pending address
    logic restore;   // context restore overrides everything
  } ovrStrobes_t;

  // Next-state source selection for the override register
  typedef enum logic [1:0] {
    SRC_HOLD    = 2'd0,
    SRC_ARM     = 2'd1,
    SRC_CLEAR   = 2'd2,
    SRC_RESTORE = 2'd3
  } ovrSrc_t;

endpackage

// File: rtl/wb_dest_override_remap.sv
module wb_dest_override_remap #(
  parameter int ADDR_W = 9,
  parameter int MODE   = 1   // 0: identity, 1: XOR with key
) (
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [ADDR_W-1:0] remapKey,
  output logic [ADDR_W-1:0] outAddr
);
  generate
    if (MODE == 0) begin : g_identity
      logic [ADDR_W-1:0] unusedKey;
      assign unusedKey = remapKey;
      assign outAddr   = inAddr;
    end else begin : g_xor
      for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        assign outAddr[b] = inAddr[b] ^ remapKey[b];
      end
    end
  endgenerate
endmodule

// File: rtl/wb_dest_override_ctrl.sv
module wb_dest_override_ctrl
  import wb_dest_override_pkg::*;
(
  input  logic        armValid,
  input  logic        exWritesReg,
  input  logic        exCondPass,
  input  logic        ctxRestore,
  input  logic        pendEn,
  output logic        writeNow,
  output ovrStrobes_t strobes,
  output ovrSrc_t     nextSrc
);
  always_comb begin
    writeNow        = exWritesReg & exCondPass;
    strobes.restore = ctxRestore;
    strobes.loadArm = armValid;
    strobes.consume = writeNow & pendEn;

    // Priority: restore, then a new arm, then consumption
    if (strobes.restore)      nextSrc = SRC_RESTORE;
    else if (strobes.loadArm) nextSrc = SRC_ARM;
    else if (strobes.consume) nextSrc = SRC_CLEAR;
    else                      nextSrc = SRC_HOLD;
  end
endmodule

// File: rtl/wb_dest_override_dp.sv
module wb_dest_override_dp
  import wb_dest_override_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int ARM_W   = 32,
  parameter int REMAP_MODE = 1,
  localparam int STATE_W = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ovrStrobes_t        strobes,
  input  ovrSrc_t            nextSrc,
  input  logic [ARM_W-1:0]   armOperand,
  input  logic [ADDR_W-1:0]  exDestAddr,
  input  logic [ADDR_W-1:0]  remapKey,
  input  logic [STATE_W-1:0] ctxRestoreState,
  output logic               pendEn,
  output logic [ADDR_W-1:0]  wbAddr,
  output logic [STATE_W-1:0] ovrState
);
  logic [ADDR_W-1:0] pendAddr;
  logic [ADDR_W-1:0] armAddr;
  logic [ADDR_W-1:0] selAddr;
  logic              nextEn;
  logic [ADDR_W-1:0] nextAddr;

  // Only the low address bits of the arm operand are retained
  assign armAddr = armOperand[ADDR_W-1:0];

  generate
    if (ARM_W > ADDR_W) begin : g_dropUpper
      logic [ARM_W-ADDR_W-1:0] droppedBits;
      assign droppedBits = armOperand[ARM_W-1:ADDR_W];
    end
  endgenerate

  always_comb begin
    nextEn   = pendEn;
    nextAddr = pendAddr;
    unique case (nextSrc)
      SRC_RESTORE: begin
        nextEn   = ctxRestoreState[STATE_W-1];
        nextAddr = ctxRestoreState[ADDR_W-1:0];
      end
      SRC_ARM: begin
        nextEn   = 1'b1;
        nextAddr = armAddr;
      end
      SRC_CLEAR: nextEn = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendEn   <= 1'b0;
      pendAddr <= '0;
    end else begin
      pendEn   <= nextEn;
      pendAddr <= nextAddr;
    end
  end

  // Consumption uses the state held at the start of the cycle
  assign selAddr  = strobes.consume ? pendAddr : exDestAddr;
  assign ovrState = {pendEn, pendAddr};

  wb_dest_override_remap #(
    .ADDR_W (ADDR_W),
    .MODE   (REMAP_MODE)
  ) u_remap (
    .inAddr   (selAddr),
    .remapKey (remapKey),
    .outAddr  (wbAddr)
  );
endmodule

// File: rtl/wb_dest_override.sv
module wb_dest_override
  import wb_dest_override_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int ARM_W      = 32,
  parameter int REMAP_MODE = 1,
  localparam int STATE_W   = ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armValid,
  input  logic [ARM_W-1:0]   armOperand,
  input  logic               exWritesReg,
  input  logic               exCondPass,
  input  logic [ADDR_W-1:0]  exDestAddr,
  input  logic [ADDR_W-1:0]  remapKey,
  input  logic               ctxRestore,
  input  logic [STATE_W-1:0] ctxRestoreState,
  output logic               wbValid,
  output logic [ADDR_W-1:0]  wbAddr,
  output logic [STATE_W-1:0] ovrState
);
  ovrStrobes_t strobes;
  ovrSrc_t     nextSrc;
  logic        pendEn;

  wb_dest_override_ctrl u_ctrl (
    .armValid    (armValid),
    .exWritesReg (exWritesReg),
    .exCondPass  (exCondPass),
    .ctxRestore  (ctxRestore),
    .pendEn      (pendEn),
    .writeNow    (wbValid),
    .strobes     (strobes),
    .nextSrc     (nextSrc)
  );

  wb_dest_override_dp #(
    .ADDR_W     (ADDR_W),
    .ARM_W      (ARM_W),
    .REMAP_MODE (REMAP_MODE)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .nextSrc         (nextSrc),
    .armOperand      (armOperand),
    .exDestAddr      (exDestAddr),
    .remapKey        (remapKey),
    .ctxRestoreState (ctxRestoreState),
    .pendEn          (pendEn),
    .wbAddr          (wbAddr),
    .ovrState        (ovrState)
  );
endmodule

// File: rtl/wb_dest_override_chk.sv
module wb_dest_override_chk #(
  parameter int ADDR_W = 9,
  parameter int ARM_W  = 32,
  localparam int STATE_W = ADDR_W + 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               armValid,
  input logic [ARM_W-1:0]   armOperand,
  input logic               exWritesReg,
  input logic               exCondPass,
  input logic [ADDR_W-1:0]  exDestAddr,
  input logic [ADDR_W-1:0]  remapKey,
  input logic               ctxRestore,
  input logic [STATE_W-1:0] ctxRestoreState,
  input logic               wbValid,
  input logic [ADDR_W-1:0]  wbAddr,
  input logic [STATE_W-1:0] ovrState
);
  assert_idle_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!ovrState[STATE_W-1] || !wbValid) |-> wbAddr == (exDestAddr ^ remapKey));

  assert_arm_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armValid && !ctxRestore) |=> ovrState == {1'b1, $past(armOperand[ADDR_W-1:0])});

  assert_consume_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (exWritesReg && exCondPass && ovrState[STATE_W-1] && !armValid && !ctxRestore)
      |=> !ovrState[STATE_W-1]);

  assert_pending_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!(exWritesReg && exCondPass) && !armValid && !ctxRestore) |=> $stable(ovrState));

  assert_restore_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctxRestore |=> ovrState == $past(ctxRestoreState));

  assert_redirect_remap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && ovrState[STATE_W-1]) |-> wbAddr == (ovrState[ADDR_W-1:0] ^ remapKey));

  assert_valid_qual_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbValid == (exWritesReg && exCondPass));
endmodule

bind wb_dest_override wb_dest_override_chk #(.ADDR_W(ADDR_W), .ARM_W(ARM_W)) u_chk (
  .clk(clk), .rstN(rstN), .armValid(armValid), .armOperand(armOperand),
  .exWritesReg(exWritesReg), .exCondPass(exCondPass), .exDestAddr(exDestAddr),
  .remapKey(remapKey), .ctxRestore(ctxRestore), .ctxRestoreState(ctxRestoreState),
  .wbValid(wbValid), .wbAddr(wbAddr), .ovrState(ovrState)
);

// File: tb/wb_dest_override_tb.sv
module wb_dest_override_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        armValid;
  logic [31:0] armOperand;
  logic        exWritesReg;
  logic        exCondPass;
  logic [8:0]  exDestAddr;
  logic [8:0]  remapKey;
  logic        ctxRestore;
  logic [9:0]  ctxRestoreState;
  logic        wbValid;
  logic [8:0]  wbAddr;
  logic [9:0]  ovrState;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wb_dest_override u_dut (
    .clk(clk), .rstN(rstN), .armValid(armValid), .armOperand(armOperand),
    .exWritesReg(exWritesReg), .exCondPass(exCondPass), .exDestAddr(exDestAddr),
    .remapKey(remapKey), .ctxRestore(ctxRestore), .ctxRestoreState(ctxRestoreState),
    .wbValid(wbValid), .wbAddr(wbAddr), .ovrState(ovrState)
  );

  task automatic check(input string tag, input logic [31:0] actual, input logic [31:0] expected);
    testsRun++;
    if (actual !== expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  // Set inputs just after a falling edge; outputs settle before the rising edge
  task automatic drive(input logic arm, input logic [31:0] op, input logic wr,
                       input logic pass, input logic [8:0] dest);
    armValid    = arm;
    armOperand  = op;
    exWritesReg = wr;
    exCondPass  = pass;
    exDestAddr  = dest;
    #1;
  endtask

  // Advance one clock and return to the falling edge; then clear the strobes
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    armValid   = 1'b0;
    ctxRestore = 1'b0;
    exWritesReg = 1'b0;
    exCondPass = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    check("R1 reset state", ovrState, 10'h000);
    drive(1'b0, 32'h0, 1'b1, 1'b1, 9'h005);
    check("R1 own dest after reset", wbAddr, 9'h005);
    check("R9 valid on write", wbValid, 1'b1);
    step();
  endtask

  task automatic t_arm();
    drive(1'b1, 32'h0000_0A5C, 1'b0, 1'b0, 9'h000);
    check("R9 arm alone not valid", wbValid, 1'b0);
    step();
    check("R2 low nine bits kept", ovrState, {1'b1, 9'h05C});
  endtask

  task automatic t_wait();
    drive(1'b0, 32'h0, 1'b1, 1'b0, 9'h010);
    check("R4 cond fail uses own dest", wbAddr, 9'h010);
    check("R9 cond fail not valid", wbValid, 1'b0);
    step();
    check("R4 pending after cond fail", ovrState, {1'b1, 9'h05C});
    drive(1'b0, 32'h0, 1'b0, 1'b1, 9'h013);
    step();
    check("R4 pending after non-writing", ovrState, {1'b1, 9'h05C});
  endtask

  task automatic t_consume();
    drive(1'b0, 32'h0, 1'b1, 1'b1, 9'h011);
    check("R3 consuming write redirected", wbAddr, 9'h05C);
    step();
    check("R3 enable cleared", ovrState[9], 1'b0);
    drive(1'b0, 32'h0, 1'b1, 1'b1, 9'h012);
    check("R3 next write own dest", wbAddr, 9'h012);
    step();
  endtask

  task automatic t_rearm();
    drive(1'b1, 32'h0000_0020, 1'b0, 1'b0, 9'h000);
    step();
    drive(1'b1, 32'hFFFF_FFF3, 1'b0, 1'b0, 9'h000);
    step();
    check("R5 second arm replaces", ovrState, {1'b1, 9'h1F3});
    drive(1'b0, 32'h0, 1'b1, 1'b1, 9'h002);
    check("R5 write uses latest arm", wbAddr, 9'h1F3);
    step();
  endtask

  task automatic t_same();
    drive(1'b1, 32'h0000_0040, 1'b0, 1'b0, 9'h000);
    step();
    drive(1'b1, 32'h0000_0041, 1'b1, 1'b1, 9'h007);
    check("R6 same cycle uses old", wbAddr, 9'h040);
    step();
    check("R6 new arm pending", ovrState, {1'b1, 9'h041});
    drive(1'b0, 32'h0, 1'b1, 1'b1, 9'h008);
    check("R6 later write uses new", wbAddr, 9'h041);
    step();
  endtask

  task automatic t_restore();
    logic [9:0] saved;
    drive(1'b1, 32'h0000_0055, 1'b0, 1'b0, 9'h000);
    step();
    saved = ovrState;
    ctxRestore = 1'b1;
    ctxRestoreState = {1'b1, 9'h099};
    drive(1'b0, 32'h0, 1'b1, 1'b1, 9'h003);
    check("R7 restore cycle sees old", wbAddr, 9'h055);
    step();
    check("R7 restored over consume", ovrState, {1'b1, 9'h099});
    ctxRestore = 1'b1;
    ctxRestoreState = saved;
    drive(1'b1, 32'h0000_0066, 1'b0, 1'b0, 9'h000);
    step();
    check("R7 restore beats arm", ovrState, {1'b1, 9'h055});
    ctxRestore = 1'b1;
    ctxRestoreState = 10'h000;
    drive(1'b0, 32'h0, 1'b0, 1'b0, 9'h000);
    step();
    check("R7 restore empty", ovrState, 10'h000);
  endtask

  task automatic t_remap();
    remapKey = 9'h101;
    drive(1'b1, 32'h0000_00F0, 1'b0, 1'b0, 9'h000);
    step();
    drive(1'b0, 32'h0, 1'b1, 1'b0, 9'h00F);
    check("R8 normal dest remapped", wbAddr, 9'h10E);
    step();
    drive(1'b0, 32'h0, 1'b1, 1'b1, 9'h00F);
    check("R8 redirected dest remapped", wbAddr, 9'h1F1);
    step();
    remapKey = 9'h000;
  endtask

  initial begin
    rstN = 1'b0;
    armValid = 1'b0; armOperand = '0; exWritesReg = 1'b0; exCondPass = 1'b0;
    exDestAddr = '0; remapKey = '0; ctxRestore = 1'b0; ctxRestoreState = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_arm();
    t_wait();
    t_consume();
    t_rearm();
    t_same();
    t_restore();
    t_remap();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule